// File: doc/BRIEF.md
# Host-Side Sequencer for a Self-Calibrating Parallel Converter

This block sits on the processor side of a parallel successive-approximation converter that calibrates itself. It drives the converter's active-low select, write, read, calibrate and auto-zero lines, and it receives the converter's active-low interrupt and its 13-bit two's-complement result. A one-cycle command asks for a calibration or for a conversion, and a conversion command states whether auto-zero is wanted. The block turns each command into a strobe sequence. Every low pulse lasts a fixed number of controller clocks, derived from the clock frequency and a width limit given in nanoseconds.

A conversion is accepted only after a calibration has finished. During a conversion the block waits for the interrupt, reads the result into a holding register and sets a valid flag. If the interrupt does not arrive within a set number of cycles, the block drops the conversion and sets an error flag. A calibration request that arrives while a conversion is still open is stored and runs as soon as that conversion is over. The block never drives the reserved combination of select low, calibrate low and read high.

Top module: `adc_hc_ctrl`

## Requirements
- R1: While reset is asserted and right after it, the select, write, read, calibrate and auto-zero lines are all high, and busy, result-valid and timeout-error are all low.
- R2: A conversion command that arrives before any calibration has finished is ignored: write never falls and busy stays low.
- R3: An accepted calibration command drives calibrate low for exactly ceil(PULSE_NS*CLK_MHZ/1000) cycles, with select, read and write high throughout. Busy then stays high for CAL_WAIT_CYC further cycles.
- R4: An accepted conversion drives select and write low together for exactly ceil(PULSE_NS*CLK_MHZ/1000) cycles and then releases both. Calibrate is never low while write is low.
- R5: The auto-zero line takes the inverse of the auto-zero command bit (1 = use auto-zero, giving a low line) in the cycle the conversion is accepted. It does not change while busy stays high.
- R6: Once the interrupt is seen low, through a two-stage synchroniser, select and read go low together for exactly ceil(ACCESS_NS*CLK_MHZ/1000) cycles. The data bus is captured into the result register when read is released, and result-valid goes high at that moment.
- R7: Result-valid clears in the cycle a new conversion is accepted. Otherwise the result and the flag hold their values.
- R8: If the interrupt is not seen low within TIMEOUT_CYC cycles after write is released, the block drops the conversion, sets timeout-error and lowers busy exactly TIMEOUT_CYC cycles after write rose. Timeout-error clears when the next command is accepted.
- R9: A calibration command that arrives while a conversion is open is held back. Its calibrate pulse starts in the same cycle that read is released, never earlier.
- R10: Select low, calibrate low and read high are never driven together.
- R11: A conversion command that arrives while busy is high is ignored and produces no extra write pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_cal_i | input | 1 | One-cycle calibration request |
| cmd_conv_i | input | 1 | One-cycle conversion request |
| cmd_az_i | input | 1 | Auto-zero select, sampled with cmd_conv_i |
| busy_o | output | 1 | A sequence is in progress |
| result_o | output | DATA_W | Last captured two's-complement result |
| result_valid_o | output | 1 | result_o holds a fresh conversion |
| timeout_err_o | output | 1 | Last conversion timed out waiting for the interrupt |
| adc_cs_n_o | output | 1 | Converter select, active low |
| adc_wr_n_o | output | 1 | Converter write/start, active low |
| adc_rd_n_o | output | 1 | Converter read enable, active low |
| adc_cal_n_o | output | 1 | Converter calibrate, active low |
| adc_az_n_o | output | 1 | Converter auto-zero level, low selects auto-zero |
| adc_int_n_i | input | 1 | Converter interrupt, active low, asynchronous |
| adc_data_i | input | DATA_W | Converter data bus |

## Verification
The bench keeps the 100 MHz clock setting, so the 200 ns strobe limit comes out at 20 cycles and the 85 ns access limit at 9 cycles. These counts are checked exactly at the pins. It shortens the calibration wait to 30 cycles and the interrupt timeout to 50 cycles. With these values the end of calibration and the timeout path fire within a few hundred cycles, and the timeout can be measured against the write edge to the exact cycle. A behavioural converter answers each start 10 cycles after write rises. It can also be muted, which makes the deferred-calibration ordering and the timeout both reachable.

// File: rtl/adc_hc_pkg.sv
package adc_hc_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CAL_LO,
    ST_CAL_RUN,
    ST_WR_LO,
    ST_WAIT_INT,
    ST_RD_LO
  } hc_state_e;

  // Nanoseconds to clock cycles, rounded up.
  function automatic int ns_to_cyc(input int ns, input int mhz);
    return (ns * mhz + 999) / 1000;
  endfunction

endpackage

// File: rtl/adc_hc_sync.sv
module adc_hc_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= RST_VAL;
        else        chain_q <= d_i;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= {STAGES{RST_VAL}};
        else        chain_q <= {chain_q[STAGES-2:0], d_i};
      end
    end
  endgenerate

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/adc_hc_timer.sv
module adc_hc_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [CNT_W-1:0] val_i,
  output logic             done_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = load_i || (cnt_q != '0);
    cnt_d  = load_i ? val_i : cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign done_o = (cnt_q == '0);

  // R4 the counter rests at zero until reloaded
  tmr_rest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !load_i) |=> done_o) else $error("timer left zero without load");
endmodule

// File: rtl/adc_hc_capture.sv
module adc_hc_capture #(
  parameter int DATA_W = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_i,
  input  logic              load_i,
  input  logic [DATA_W-1:0] din_i,
  output logic [DATA_W-1:0] dout_o,
  output logic              valid_o
);
  logic [DATA_W-1:0] data_q;
  logic              valid_q, valid_d, valid_en;

  always_comb begin
    valid_en = clr_i || load_i;
    valid_d  = load_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      data_q <= '0;
    else if (load_i) data_q <= din_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        valid_q <= 1'b0;
    else if (valid_en) valid_q <= valid_d;
  end

  assign dout_o  = data_q;
  assign valid_o = valid_q;

  // R6
  valid_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(valid_q) |-> $past(load_i)) else $error("valid rose without capture");
  // R7
  valid_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !load_i) |=> !valid_q) else $error("valid not cleared");
endmodule

// File: rtl/adc_hc_ctrl.sv
module adc_hc_ctrl
  import adc_hc_pkg::*;
#(
  parameter int CLK_MHZ      = 100,
  parameter int PULSE_NS     = 200,
  parameter int ACCESS_NS    = 85,
  parameter int CAL_WAIT_CYC = 71000,
  parameter int TIMEOUT_CYC  = 4000,
  parameter int DATA_W       = 13,
  parameter int SYNC_STAGES  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_cal_i,
  input  logic              cmd_conv_i,
  input  logic              cmd_az_i,
  output logic              busy_o,
  output logic [DATA_W-1:0] result_o,
  output logic              result_valid_o,
  output logic              timeout_err_o,
  output logic              adc_cs_n_o,
  output logic              adc_wr_n_o,
  output logic              adc_rd_n_o,
  output logic              adc_cal_n_o,
  output logic              adc_az_n_o,
  input  logic              adc_int_n_i,
  input  logic [DATA_W-1:0] adc_data_i
);
  localparam int PULSE_CYC = ns_to_cyc(PULSE_NS, CLK_MHZ);
  localparam int ACC_CYC   = ns_to_cyc(ACCESS_NS, CLK_MHZ);
  localparam int MAX_A     = (PULSE_CYC > ACC_CYC) ? PULSE_CYC : ACC_CYC;
  localparam int MAX_B     = (CAL_WAIT_CYC > TIMEOUT_CYC) ? CAL_WAIT_CYC : TIMEOUT_CYC;
  localparam int MAX_CYC   = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int CNT_W     = $clog2(MAX_CYC + 1);
  localparam logic [CNT_W-1:0] LD_PULSE = CNT_W'(PULSE_CYC - 1);
  localparam logic [CNT_W-1:0] LD_ACC   = CNT_W'(ACC_CYC - 1);
  localparam logic [CNT_W-1:0] LD_CALW  = CNT_W'(CAL_WAIT_CYC - 1);
  localparam logic [CNT_W-1:0] LD_TMO   = CNT_W'(TIMEOUT_CYC - 1);

  hc_state_e        state_q, state_d;
  logic             cal_ok_q, cal_ok_d;
  logic             cal_pend_q, cal_pend_d;
  logic             az_q, az_d;
  logic             tmo_q, tmo_d;
  logic             tmr_load;
  logic [CNT_W-1:0] tmr_val;
  logic             tmr_done;
  logic             int_s_n;
  logic             cap_clr, cap_load;
  logic             conv_open;

  adc_hc_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_int_sync (
    .clk(clk), .rst_n(rst_n), .d_i(adc_int_n_i), .q_o(int_s_n)
  );

  adc_hc_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .load_i(tmr_load), .val_i(tmr_val), .done_o(tmr_done)
  );

  adc_hc_capture #(.DATA_W(DATA_W)) u_capture (
    .clk(clk), .rst_n(rst_n), .clr_i(cap_clr), .load_i(cap_load),
    .din_i(adc_data_i), .dout_o(result_o), .valid_o(result_valid_o)
  );

  assign conv_open = (state_q == ST_WR_LO) || (state_q == ST_WAIT_INT) ||
                     (state_q == ST_RD_LO);

  // Next-state process
  always_comb begin
    state_d    = state_q;
    cal_ok_d   = cal_ok_q;
    cal_pend_d = cal_pend_q;
    az_d       = az_q;
    tmo_d      = tmo_q;
    tmr_load   = 1'b0;
    tmr_val    = '0;
    cap_clr    = 1'b0;
    cap_load   = 1'b0;

    if (conv_open && cmd_cal_i) cal_pend_d = 1'b1;

    unique case (state_q)
      ST_IDLE: begin
        if (cmd_cal_i) begin
          state_d  = ST_CAL_LO;
          tmr_load = 1'b1;
          tmr_val  = LD_PULSE;
          tmo_d    = 1'b0;
        end else if (cmd_conv_i && cal_ok_q) begin
          state_d  = ST_WR_LO;
          tmr_load = 1'b1;
          tmr_val  = LD_PULSE;
          tmo_d    = 1'b0;
          az_d     = ~cmd_az_i;
          cap_clr  = 1'b1;
        end
      end
      ST_CAL_LO: begin
        if (tmr_done) begin
          state_d  = ST_CAL_RUN;
          tmr_load = 1'b1;
          tmr_val  = LD_CALW;
        end
      end
      ST_CAL_RUN: begin
        if (tmr_done) begin
          state_d  = ST_IDLE;
          cal_ok_d = 1'b1;
        end
      end
      ST_WR_LO: begin
        if (tmr_done) begin
          state_d  = ST_WAIT_INT;
          tmr_load = 1'b1;
          tmr_val  = LD_TMO;
        end
      end
      ST_WAIT_INT: begin
        if (!int_s_n) begin
          state_d  = ST_RD_LO;
          tmr_load = 1'b1;
          tmr_val  = LD_ACC;
        end else if (tmr_done) begin
          tmo_d = 1'b1;
          if (cal_pend_d) begin
            state_d    = ST_CAL_LO;
            tmr_load   = 1'b1;
            tmr_val    = LD_PULSE;
            cal_pend_d = 1'b0;
          end else begin
            state_d = ST_IDLE;
          end
        end
      end
      ST_RD_LO: begin
        if (tmr_done) begin
          cap_load = 1'b1;
          if (cal_pend_d) begin
            state_d    = ST_CAL_LO;
            tmr_load   = 1'b1;
            tmr_val    = LD_PULSE;
            cal_pend_d = 1'b0;
          end else begin
            state_d = ST_IDLE;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // Register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      cal_ok_q   <= 1'b0;
      cal_pend_q <= 1'b0;
      az_q       <= 1'b1;
      tmo_q      <= 1'b0;
    end else begin
      state_q    <= state_d;
      cal_ok_q   <= cal_ok_d;
      cal_pend_q <= cal_pend_d;
      az_q       <= az_d;
      tmo_q      <= tmo_d;
    end
  end

  assign adc_cs_n_o    = !((state_q == ST_WR_LO) || (state_q == ST_RD_LO));
  assign adc_wr_n_o    = (state_q != ST_WR_LO);
  assign adc_rd_n_o    = (state_q != ST_RD_LO);
  assign adc_cal_n_o   = (state_q != ST_CAL_LO);
  assign adc_az_n_o    = az_q;
  assign busy_o        = (state_q != ST_IDLE);
  assign timeout_err_o = tmo_q;

  // Low-run counters used only by the checks below
  logic [15:0] wr_run_q, rd_run_q, cal_run_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_run_q  <= '0;
      rd_run_q  <= '0;
      cal_run_q <= '0;
    end else begin
      wr_run_q  <= adc_wr_n_o  ? '0 : wr_run_q + 1'b1;
      rd_run_q  <= adc_rd_n_o  ? '0 : rd_run_q + 1'b1;
      cal_run_q <= adc_cal_n_o ? '0 : cal_run_q + 1'b1;
    end
  end

  // R10
  no_testmode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(!adc_cs_n_o && !adc_cal_n_o && adc_rd_n_o)) else $error("test mode driven");
  // R4
  cal_wr_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(!adc_cal_n_o && !adc_wr_n_o)) else $error("calibrate low during write");
  // R3
  cal_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !adc_cal_n_o |-> (adc_cs_n_o && adc_rd_n_o && adc_wr_n_o)) else $error("strobe during calibrate");
  // R3
  cal_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(adc_cal_n_o) |-> (cal_run_q == 16'(PULSE_CYC))) else $error("calibrate width");
  // R4
  wr_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(adc_wr_n_o) |-> (wr_run_q == 16'(PULSE_CYC))) else $error("write width");
  // R6
  rd_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(adc_rd_n_o) |-> (rd_run_q == 16'(ACC_CYC))) else $error("read width");
  // R5
  az_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && $past(busy_o)) |-> $stable(adc_az_n_o)) else $error("auto-zero moved");
  // R8
  tmo_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(timeout_err_o) |-> (adc_rd_n_o && adc_wr_n_o)) else $error("timeout with strobe");
endmodule

// File: tb/tb_adc_hc_ctrl.sv
module tb_adc_hc_ctrl;
  localparam int TB_PULSE = 20;
  localparam int TB_ACC   = 9;
  localparam int TB_CALW  = 30;
  localparam int TB_TMO   = 50;
  localparam int LAT      = 10;
  localparam int NVEC     = 6;
  // {auto-zero request, expected 13-bit result}
  localparam logic [13:0] VEC [NVEC] = '{
    {1'b0, 13'h0000}, {1'b1, 13'h0FFF}, {1'b0, 13'h1000},
    {1'b1, 13'h1FFF}, {1'b1, 13'h0555}, {1'b0, 13'h1AAA}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic        cmd_cal = 1'b0, cmd_conv = 1'b0, cmd_az = 1'b0;
  logic        busy, valid, tmo, cs_n, wr_n, rd_n, cal_n, az_n;
  logic        int_n = 1'b1;
  logic        mute = 1'b0;
  logic [12:0] data = '0, result;

  adc_hc_ctrl #(.CAL_WAIT_CYC(TB_CALW), .TIMEOUT_CYC(TB_TMO)) dut (
    .clk(clk), .rst_n(rst_n), .cmd_cal_i(cmd_cal), .cmd_conv_i(cmd_conv),
    .cmd_az_i(cmd_az), .busy_o(busy), .result_o(result), .result_valid_o(valid),
    .timeout_err_o(tmo), .adc_cs_n_o(cs_n), .adc_wr_n_o(wr_n), .adc_rd_n_o(rd_n),
    .adc_cal_n_o(cal_n), .adc_az_n_o(az_n), .adc_int_n_i(int_n), .adc_data_i(data)
  );

  int checks = 0, fails = 0;
  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Pin monitor
  int   cyc = 0, wr_run = 0, rd_run = 0, cal_run = 0, busy_run = 0;
  int   wr_last = 0, rd_last = 0, cal_last = 0, busy_last = 0;
  int   wr_falls = 0, tm_viol = 0;
  int   cal_fall_t = 0, rd_rise_t = 0, wr_rise_t = 0, busy_fall_t = 0;
  logic az_at_wr = 1'b1;
  logic wr_p = 1'b1, rd_p = 1'b1, cal_p = 1'b1, busy_p = 1'b0;
  int   cd = 0;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (!wr_n) wr_run <= wr_run + 1;
    else if (!wr_p) begin wr_last <= wr_run; wr_run <= 0; wr_rise_t <= cyc; end
    if (!wr_n && wr_p) begin wr_falls <= wr_falls + 1; az_at_wr <= az_n; end
    if (!rd_n) rd_run <= rd_run + 1;
    else if (!rd_p) begin rd_last <= rd_run; rd_run <= 0; rd_rise_t <= cyc; end
    if (!cal_n) cal_run <= cal_run + 1;
    else if (!cal_p) begin cal_last <= cal_run; cal_run <= 0; end
    if (!cal_n && cal_p) cal_fall_t <= cyc;
    if (busy) busy_run <= busy_run + 1;
    else if (busy_p) begin busy_last <= busy_run; busy_run <= 0; busy_fall_t <= cyc; end
    if (rst_n && !cs_n && !cal_n && rd_n) tm_viol <= tm_viol + 1;
    wr_p <= wr_n; rd_p <= rd_n; cal_p <= cal_n; busy_p <= busy;
  end

  // Behavioural converter: interrupt LAT cycles after write rises
  always @(posedge clk) begin
    if (wr_n && !wr_p && !mute) cd <= LAT;
    else if (cd > 1) cd <= cd - 1;
    else if (cd == 1) begin cd <= 0; int_n <= 1'b0; end
    if ((!cs_n && !rd_n) || !wr_n || !cal_n) int_n <= 1'b1;
  end

  task automatic pulse_cmd(input bit c_conv, input bit c_az, input bit c_cal);
    @(negedge clk);
    cmd_conv = c_conv; cmd_az = c_az; cmd_cal = c_cal;
    @(negedge clk);
    cmd_conv = 1'b0; cmd_cal = 1'b0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 1000; i++) begin
      @(negedge clk);
      if (!busy) break;
    end
    @(negedge clk);
  endtask

  task automatic wait_valid();
    for (int i = 0; i < 1000; i++) begin
      if (valid) break;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int wf0;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk(cs_n && wr_n && rd_n && cal_n && az_n, "R1 strobes", {cs_n, wr_n, rd_n, cal_n, az_n}, 31);
    chk(!busy && !valid && !tmo, "R1 flags", {busy, valid, tmo}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(cs_n && wr_n && rd_n && cal_n && az_n && !busy, "R1 after release", busy, 0);

    // R2 conversion before calibration is ignored
    pulse_cmd(1'b1, 1'b0, 1'b0);
    repeat (5) @(negedge clk);
    chk(!busy && wr_falls == 0, "R2 ignored", wr_falls, 0);

    // R3 calibration
    pulse_cmd(1'b0, 1'b0, 1'b1);
    wait_idle();
    chk(cal_last == TB_PULSE, "R3 cal width", cal_last, TB_PULSE);
    chk(busy_last == TB_PULSE + TB_CALW, "R3 busy span", busy_last, TB_PULSE + TB_CALW);

    // Vector table: conversions with and without auto-zero
    for (int v = 0; v < NVEC; v++) begin
      data = VEC[v][12:0];
      pulse_cmd(1'b1, VEC[v][13], 1'b0);
      chk(busy && !valid, "R7 valid cleared on accept", valid, 0);
      chk(az_n == !VEC[v][13], "R5 az level", az_n, !VEC[v][13]);
      wait_valid();
      chk(result == VEC[v][12:0], "R6 result", result, VEC[v][12:0]);
      wait_idle();
      chk(wr_last == TB_PULSE, "R4 write width", wr_last, TB_PULSE);
      chk(rd_last == TB_ACC, "R6 read width", rd_last, TB_ACC);
      chk(az_at_wr == !VEC[v][13] && az_n == !VEC[v][13], "R5 az held", az_n, !VEC[v][13]);
      chk(valid && result == VEC[v][12:0], "R7 result held", result, VEC[v][12:0]);
    end

    // R11 second conversion while busy
    wf0 = wr_falls;
    data = 13'h0123;
    pulse_cmd(1'b1, 1'b0, 1'b0);
    repeat (3) @(negedge clk);
    pulse_cmd(1'b1, 1'b1, 1'b0);
    wait_idle();
    chk(wr_falls == wf0 + 1, "R11 one write pulse", wr_falls - wf0, 1);
    chk(az_n == 1'b1, "R11 az unchanged", az_n, 1);

    // R9 calibration deferred until the read completes
    data = 13'h0ABC;
    pulse_cmd(1'b1, 1'b0, 1'b0);
    repeat (3) @(negedge clk);
    pulse_cmd(1'b0, 1'b0, 1'b1);
    wait_valid();
    chk(result == 13'h0ABC, "R9 result before cal", result, 13'h0ABC);
    wait_idle();
    chk(cal_fall_t == rd_rise_t, "R9 cal after read", cal_fall_t, rd_rise_t);
    chk(cal_last == TB_PULSE, "R9 deferred cal width", cal_last, TB_PULSE);

    // R8 timeout when the interrupt never comes
    mute = 1'b1;
    pulse_cmd(1'b1, 1'b0, 1'b0);
    wait_idle();
    chk(tmo && !valid, "R8 timeout flag", tmo, 1);
    chk(busy_fall_t - wr_rise_t == TB_TMO, "R8 timeout span", busy_fall_t - wr_rise_t, TB_TMO);
    chk(cs_n && rd_n && wr_n, "R8 strobes released", {cs_n, rd_n, wr_n}, 7);
    mute = 1'b0;
    data = 13'h1555;
    pulse_cmd(1'b1, 1'b0, 1'b0);
    chk(!tmo, "R8 cleared on accept", tmo, 0);
    wait_idle();
    chk(valid && result == 13'h1555, "R8 recovery result", result, 13'h1555);

    // R10 reserved combination never seen
    chk(tm_viol == 0, "R10 no test mode", tm_viol, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule